// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a 32-bit physical address. It walks a two-level table held in memory. A request carries the virtual address, a read or write flag and the physical base of the top-level directory. The walker reads one directory word and then one table word through a single word-wide memory port. It sets the usage flags in the table word and returns either the physical address or a fault code.

The virtual address has three fields. Bits 31:22 select the directory slot, bits 21:12 select the table slot, and bits 11:0 are the byte offset inside the 4 KiB page. Each entry is one 32-bit word with these fields:

- bit 0: present
- bit 1: writable
- bit 5: accessed
- bit 6: modified
- bit 8: global
- bits 31:12: frame number

The memory port uses a valid/ready request handshake. Read data comes back on a separate one-cycle strobe, one or more cycles after the request is accepted. Only one request is outstanding at a time. The walker accepts a new translation only while it is idle. It presents the result for one cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `mem_valid` and `rsp_valid` are 0.
- R2: The first memory access of a walk is a read at address `dir_base + vaddr[31:22]*4`.
- R3: When the directory word has bit 0 set, the second access is a read at `{dir_word[31:12], vaddr[21:12], 2'b00}`.
- R4: When the directory word has bit 0 clear, the walk ends with `rsp_fault` = 1 and `rsp_paddr` = 0. No further memory access is made.
- R5: When the table word has bit 0 clear, the walk ends with `rsp_fault` = 1 and `rsp_paddr` = 0. No write is made.
- R6: A write request whose table word has bit 1 clear ends with `rsp_fault` = 2 and `rsp_paddr` = 0, and no write is made. A read request to the same page succeeds.
- R7: A successful walk returns `rsp_fault` = 0 and `rsp_paddr` = `{table_word[31:12], vaddr[11:0]}`.
- R8: A successful walk writes the table word back to the address it was read from. The written value has bit 5 set, bit 6 set when the request is a write, and every other bit (including bit 8) unchanged.
- R9: If the written value would equal the table word as read, no write is issued.
- R10: A memory request held while `mem_ready` is low keeps `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stable. `rsp_valid` is a single-cycle pulse. `rsp_fault` only takes the values 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| dir_base | input | 32 | Physical base address of the directory |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 write protection |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets these corner cases:

- **Missing entry at each level.** A walker that ignores the directory present bit would go on to read a table at a garbage address.
- **Write to a read-only page.** A design that checks protection after updating the usage flags would leak a write-back despite the fault.
- **Usage flags already set.** Here the write-back must be skipped; a design that always writes back produces an extra memory write.
- **Preserved bits on write-back.** The global bit and the frame must survive the write-back; a mask error would corrupt them.
- **Port timing.** A random ready signal and random read latency expose a walker that advances without a handshake or drops its address while stalled.
- **Top directory slot.** Slot 1023 exercises the address sum.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int BIT_P     = 0,
  parameter int BIT_W     = 1,
  parameter int BIT_A     = 5,
  parameter int BIT_D     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic [VA_W-1:0] dir_base,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic            mem_rvalid,
  input  logic [VA_W-1:0] mem_rdata
);
  localparam int FRM_W = VA_W - OFF_W;
  localparam int TI_LO = OFF_W;
  localparam int DI_LO = OFF_W + IDX_W;
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_MISS = 2'd1;
  localparam logic [1:0] F_PROT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_TBL_REQ, S_TBL_WAIT, S_WBACK, S_DONE
  } state_t;

  state_t          state;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [VA_W-1:0] ent_addr;
  logic [VA_W-1:0] wb_data;
  logic [VA_W-1:0] pte_upd;

  assign pte_upd = mem_rdata | (VA_W'(1) << BIT_A) | (wr_q ? (VA_W'(1) << BIT_D) : '0);

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_DONE);
  assign mem_valid = (state == S_DIR_REQ) || (state == S_TBL_REQ) || (state == S_WBACK);
  assign mem_we    = (state == S_WBACK);
  assign mem_addr  = ent_addr;
  assign mem_wdata = wb_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      ent_addr  <= '0;
      wb_data   <= '0;
      rsp_paddr <= '0;
      rsp_fault <= F_NONE;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q     <= req_vaddr;
          wr_q     <= req_write;
          ent_addr <= dir_base + {{(VA_W-IDX_W-2){1'b0}}, req_vaddr[VA_W-1:DI_LO], 2'b00};
          state    <= S_DIR_REQ;
        end
        S_DIR_REQ: if (mem_ready) state <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rvalid) begin
          if (!mem_rdata[BIT_P]) begin
            rsp_fault <= F_MISS;
            rsp_paddr <= '0;
            state     <= S_DONE;
          end else begin
            ent_addr <= {mem_rdata[VA_W-1:OFF_W], va_q[DI_LO-1:TI_LO], 2'b00};
            state    <= S_TBL_REQ;
          end
        end
        S_TBL_REQ: if (mem_ready) state <= S_TBL_WAIT;
        S_TBL_WAIT: if (mem_rvalid) begin
          if (!mem_rdata[BIT_P]) begin
            rsp_fault <= F_MISS;
            rsp_paddr <= '0;
            state     <= S_DONE;
          end else if (wr_q && !mem_rdata[BIT_W]) begin
            rsp_fault <= F_PROT;
            rsp_paddr <= '0;
            state     <= S_DONE;
          end else begin
            rsp_fault <= F_NONE;
            rsp_paddr <= {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
            wb_data   <= pte_upd;
            state     <= (pte_upd != mem_rdata) ? S_WBACK : S_DONE;
          end
        end
        S_WBACK: if (mem_ready) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3)); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_NONE) |-> (rsp_paddr == '0)); // R4
  AST_KEEP_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == F_NONE) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0])); // R7
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> mem_wdata[BIT_A]); // R8
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && wr_q) |-> mem_wdata[BIT_D]); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid); // R1
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] dir_base = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [4];
  int          rd_n;
  int          wr_n;
  logic [31:0] wr_a, wr_d;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [31:0] pend_a = '0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        mem_run = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .dir_base(dir_base),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_run) begin
      mem_rvalid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(pend_a);
          pend       = 1'b0;
        end else lat--;
      end
      if (prev_stall) check(mem_valid && mem_addr == prev_addr, "R10 hold", mem_addr, prev_addr);
      mem_ready = ($urandom % 3) != 0;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          wr_n++; wr_a = mem_addr; wr_d = mem_wdata; mem[mem_addr] = mem_wdata;
        end else begin
          if (rd_n < 4) rd_log[rd_n] = mem_addr;
          rd_n++; pend = 1'b1; pend_a = mem_addr; lat = $urandom % 3;
        end
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
    end
  end

  task automatic walk(input logic [31:0] base, input logic [31:0] va, input bit wr);
    logic [31:0] pde_a, pde, pte_a, pte, upd, exp_pa;
    logic [1:0]  exp_f;
    int          exp_rd, exp_wr;
    pde_a = base + {20'h0, va[31:22], 2'b00};
    pde   = rd(pde_a);
    pte_a = {pde[31:12], va[21:12], 2'b00};
    pte   = rd(pte_a);
    upd   = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    exp_wr = 0; exp_pa = 0;
    if (!pde[0]) begin exp_f = 1; exp_rd = 1; end
    else if (!pte[0]) begin exp_f = 1; exp_rd = 2; end
    else if (wr && !pte[1]) begin exp_f = 2; exp_rd = 2; end
    else begin
      exp_f = 0; exp_rd = 2; exp_pa = {pte[31:12], va[11:0]};
      exp_wr = (upd != pte) ? 1 : 0;
    end
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    dir_base = base; req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_fault == exp_f, "R4/R5/R6 fault", 32'(rsp_fault), 32'(exp_f));
    check(rsp_paddr == exp_pa, "R7 paddr", rsp_paddr, exp_pa);
    check(rd_n == exp_rd, "R4 read count", rd_n, exp_rd);
    if (rd_n >= 1) check(rd_log[0] == pde_a, "R2 dir addr", rd_log[0], pde_a);
    if (rd_n >= 2 && exp_rd == 2) check(rd_log[1] == pte_a, "R3 tbl addr", rd_log[1], pte_a);
    check(wr_n == exp_wr, "R9/R5/R6 write count", wr_n, exp_wr);
    if (exp_wr == 1 && wr_n == 1) begin
      check(wr_a == pte_a, "R8 wb addr", wr_a, pte_a);
      check(wr_d == upd, "R8 wb data", wr_d, upd);
    end
    @(negedge clk);
    check(!rsp_valid, "R10 pulse", 32'(rsp_valid), 0);
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] va,
                       input logic [31:0] pde, input logic [31:0] pte);
    mem.delete();
    mem[base + {20'h0, va[31:22], 2'b00}] = pde;
    mem[{pde[31:12], va[21:12], 2'b00}] = pte;
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid, "R1 reset",
          {29'h0, req_ready, mem_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    mem_run = 1'b1;

    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'h1234_5003);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b0);   // R8 accessed only
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'h1234_5003);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b1);   // R8 accessed and modified
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'h1234_5023);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b0);   // R9 already accessed
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'h1234_5063);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b1);   // R9 both set
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'h1234_5001);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b1);   // R6 read-only write
    walk(32'h0001_0000, 32'h0040_1abc, 1'b0);   // R6 read-only read
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0000, 32'h1234_5003);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b0);   // R4 missing directory entry
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'h1234_5002);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b1);   // R5 missing table entry
    setup(32'h0001_0000, 32'h0040_1abc, 32'h8002_0001, 32'hABCD_E103);
    walk(32'h0001_0000, 32'h0040_1abc, 1'b1);   // R8 global bit kept
    setup(32'h0003_0004, 32'hFFFF_FFFF, 32'h8005_0001, 32'h0F0F_0003);
    walk(32'h0003_0004, 32'hFFFF_FFFF, 1'b0);   // R2 top slot

    for (int i = 0; i < 300; i++) begin
      logic [31:0] b, v, d, t;
      b = {1'b0, 19'($urandom), 12'h0};
      v = $urandom;
      d = {1'b1, 19'($urandom), 12'($urandom)};
      d[0] = ($urandom % 8) != 0;
      t = $urandom;
      t[0] = ($urandom % 8) != 0;
      setup(b, v, d, t);
      walk(b, v, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule